// File: doc/BRIEF.md
# Serial Infrared Pulse Codec

This block sits between a UART and an infrared transceiver. On the transmit side it watches the UART's NRZ output together with the UART's 16x oversampling tick. It turns every low bit into a short high pulse on the infrared output, and a high bit into no pulse. On the receive side it turns each pulse seen on the infrared input back into a low bit on the NRZ line that feeds the UART receiver.

A mode input bypasses the codec, so the UART pins connect straight through. A second input picks the pulse width. In normal width a pulse lasts three ticks, which is 3/16 of a bit. In low-power width a pulse lasts three periods of the system clock divided by a programmable value, so the width does not depend on the baud rate. The link is half-duplex: while a frame is being sent, the receive path is blanked so the block does not hear its own echo.

Top module: `sir_codec`

## Requirements
- R1: With `sir_en` low, `sir_out` equals `uart_txd` and `uart_rxd` equals `sir_in` in the same cycle, with no register in between.
- R2: With `sir_en` high, a bit period is 16 ticks of `baud_tick`. While idle, the first tick that sees `uart_txd` low starts a frame. Each later 16th tick is a bit boundary. A bit sampled low (0) at its start tick emits exactly one pulse, and that pulse rises in the cycle after that tick. A bit sampled high (1) emits none, and a 1 at a boundary ends the frame. Pulse rises within a frame are a whole number of bit periods apart.
- R3: With `lp_mode` low (0), `sir_out` stays high for exactly three ticks. It falls in the cycle after the third tick that follows its start.
- R4: With `lp_mode` high (1) and `lp_div` = N (9 bits, N from 1 to 256), `sir_out` stays high for exactly 3*N clock cycles, whatever the tick rate.
- R5: With `lp_mode` high and `lp_div` = 0, no pulse is emitted at all.
- R6: With `sir_en` high and no frame being sent, a rising edge on `sir_in` drives `uart_rxd` low. The low starts three cycles after the edge is driven (two synchronizer stages plus one register). It returns high on the 16th tick after it went low.
- R7: While a transmit frame is active or a pulse is being emitted, `uart_rxd` stays high and pulses on `sir_in` have no effect.
- R8: During reset with `sir_en` high, `sir_out` is low and `uart_rxd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the reference for low-power timing |
| rst_n | input | 1 | Active-low synchronous reset |
| sir_en | input | 1 | 1 = infrared coding, 0 = direct pass-through |
| lp_mode | input | 1 | 1 = fixed low-power pulse width, 0 = 3/16-bit width |
| lp_div | input | 9 | Low-power clock divisor N; 0 disables low-power pulses |
| baud_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| uart_txd | input | 1 | NRZ transmit data from the UART |
| uart_rxd | output | 1 | NRZ receive data to the UART |
| sir_in | input | 1 | Infrared receive pulses, active high |
| sir_out | output | 1 | Infrared transmit pulses, active high |

## Verification
Two functions can act in the same cycle: sending a frame and detecting an incoming pulse, because the echo of the block's own pulse arrives while its frame is still going out. The bench provokes this by driving pulses on `sir_in` at random offsets in the middle of transmitted frames. It passes only if `uart_rxd` never goes low during those frames while the transmitted pulse count, width and spacing remain as expected. Separate receive-only frames, sampled in the middle of each bit, show that the receive path works once the transmitter is idle.

// File: rtl/sir_pkg.sv
package sir_pkg;

  typedef enum logic {PW_NORMAL = 1'b0, PW_LOWPOW = 1'b1} pw_mode_e;

  // True when a counter running 0..len-1 sits on its final value.
  function automatic logic at_last(input int unsigned cnt, input int unsigned len);
    return cnt == len - 1;
  endfunction

  // Low-power pulse length in reference cycles for divisor div.
  function automatic int unsigned lp_cycles(input int unsigned div, input int unsigned periods);
    return div * periods;
  endfunction

endpackage

// File: rtl/sir_lp_timer.sv
module sir_lp_timer
  import sir_pkg::*;
#(
  parameter int DIV_W      = 9,
  parameter int LP_PERIODS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             busy
);
  localparam int PC_W = $clog2(LP_PERIODS + 1);

  logic [DIV_W-1:0] sub_cnt;
  logic [PC_W-1:0]  per_cnt;
  logic             div_zero;
  logic             sub_wrap;
  logic             per_last;

  assign div_zero = (div == '0);
  assign sub_wrap = at_last(32'(sub_cnt), 32'(div));
  assign per_last = at_last(32'(per_cnt), LP_PERIODS);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy    <= 1'b0;
      sub_cnt <= '0;
      per_cnt <= '0;
    end else if (start) begin
      busy    <= !div_zero;
      sub_cnt <= '0;
      per_cnt <= '0;
    end else if (busy) begin
      if (sub_wrap) begin
        sub_cnt <= '0;
        if (per_last) busy <= 1'b0;
        else          per_cnt <= per_cnt + 1'b1;
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
    end
  end

  // R5: a zero divisor never lets a low-power pulse begin
  a_r5_zero_div_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (div_zero && !busy) |=> !busy);

endmodule

// File: rtl/sir_encoder.sv
module sir_encoder
  import sir_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3,
  parameter int LP_PERIODS  = 3,
  parameter int DIV_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             lp_mode,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             tick,
  input  logic             txd,
  output logic             ir_pulse,
  output logic             busy
);
  localparam int PH_W = $clog2(OVS);
  localparam int PT_W = $clog2(PULSE_TICKS + 1);

  logic            act;
  logic [PH_W-1:0] ph;
  logic            nq;
  logic [PT_W-1:0] ncnt;
  pw_mode_e        pmode;
  logic            lp_busy;

  // Named events for the checks below.
  logic bit_end;
  logic start;
  logic lp_start;
  logic lp_clr;

  assign bit_end  = act && tick && at_last(32'(ph), OVS);
  assign start    = en && tick && !txd && (!act || bit_end);
  assign lp_start = start && lp_mode;
  assign lp_clr   = !en || (start && !lp_mode);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      act   <= 1'b0;
      ph    <= '0;
      pmode <= PW_NORMAL;
    end else if (start) begin
      act   <= 1'b1;
      ph    <= '0;
      pmode <= lp_mode ? PW_LOWPOW : PW_NORMAL;
    end else if (bit_end) begin
      act <= 1'b0;
      ph  <= '0;
    end else if (act && tick) begin
      ph <= ph + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      nq   <= 1'b0;
      ncnt <= '0;
    end else if (start) begin
      nq   <= !lp_mode;
      ncnt <= '0;
    end else if (nq && tick) begin
      if (at_last(32'(ncnt), PULSE_TICKS)) nq <= 1'b0;
      else                                 ncnt <= ncnt + 1'b1;
    end
  end

  sir_lp_timer #(
    .DIV_W      (DIV_W),
    .LP_PERIODS (LP_PERIODS)
  ) u_lp_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (lp_clr),
    .start (lp_start),
    .div   (lp_div),
    .busy  (lp_busy)
  );

  assign ir_pulse = (pmode == PW_LOWPOW) ? lp_busy : nq;
  assign busy     = act || nq || lp_busy;

  // R2: a pulse only begins right after a tick that saw a low bit
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_pulse) |-> ($past(tick) && !$past(txd) && $past(en)));

  // R3: a normal-width pulse only ends on a tick
  a_r3_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nq) && $past(en)) |-> $past(tick));

endmodule

// File: rtl/sir_decoder.sv
module sir_decoder
  import sir_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic blank,
  input  logic tick,
  input  logic ir_in,
  output logic nrz_low
);
  localparam int PH_W = $clog2(OVS);

  logic [SYNC_STAGES-1:0] sy;
  logic                   prev;
  logic [PH_W-1:0]        cnt;
  logic                   edge_seen;

  assign edge_seen = sy[SYNC_STAGES-1] && !prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy   <= '0;
      prev <= 1'b0;
    end else begin
      sy   <= {sy[SYNC_STAGES-2:0], ir_in};
      prev <= sy[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en || blank) begin
      nrz_low <= 1'b0;
      cnt     <= '0;
    end else if (edge_seen) begin
      nrz_low <= 1'b1;
      cnt     <= '0;
    end else if (nrz_low && tick) begin
      if (at_last(32'(cnt), OVS)) nrz_low <= 1'b0;
      else                        cnt <= cnt + 1'b1;
    end
  end

  // R6: a detected edge outside blanking always starts a low bit
  a_r6_edge_sets_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !blank && edge_seen) |=> nrz_low);

  // R6: a stretched low ends only on a tick
  a_r6_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nrz_low) && $past(en) && !$past(blank)) |-> $past(tick));

  // R7: blanking wipes any pending receive bit
  a_r7_blank_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && blank) |=> !nrz_low);

endmodule

// File: rtl/sir_codec.sv
module sir_codec
  import sir_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int PULSE_TICKS = 3,
  parameter int LP_PERIODS  = 3,
  parameter int DIV_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sir_en,
  input  logic             lp_mode,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             baud_tick,
  input  logic             uart_txd,
  output logic             uart_rxd,
  input  logic             sir_in,
  output logic             sir_out
);
  logic enc_pulse;
  logic enc_busy;
  logic dec_low;

  sir_encoder #(
    .OVS         (OVS),
    .PULSE_TICKS (PULSE_TICKS),
    .LP_PERIODS  (LP_PERIODS),
    .DIV_W       (DIV_W)
  ) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (sir_en),
    .lp_mode  (lp_mode),
    .lp_div   (lp_div),
    .tick     (baud_tick),
    .txd      (uart_txd),
    .ir_pulse (enc_pulse),
    .busy     (enc_busy)
  );

  sir_decoder #(
    .OVS         (OVS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (sir_en),
    .blank   (enc_busy),
    .tick    (baud_tick),
    .ir_in   (sir_in),
    .nrz_low (dec_low)
  );

  assign sir_out  = sir_en ? enc_pulse : uart_txd;
  assign uart_rxd = sir_en ? !dec_low  : sir_in;

  // R8: both lines idle once reset has been seen at a clock edge
  a_r8_reset_idle: assert property (@(posedge clk)
    (!$past(rst_n) && sir_en) |-> (!sir_out && uart_rxd));

endmodule

// File: tb/test_sir_codec.sv
module test_sir_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sir_en = 1'b1;
  logic       lp_mode = 1'b0;
  logic [8:0] lp_div = 9'd0;
  logic       baud_tick = 1'b0;
  logic       uart_txd = 1'b1;
  logic       sir_in = 1'b0;
  logic       uart_rxd;
  logic       sir_out;

  always #2 clk = ~clk;

  sir_codec i_sir_codec (
    .clk(clk), .rst_n(rst_n), .sir_en(sir_en), .lp_mode(lp_mode), .lp_div(lp_div),
    .baud_tick(baud_tick), .uart_txd(uart_txd), .uart_rxd(uart_rxd),
    .sir_in(sir_in), .sir_out(sir_out)
  );

  int n_chk = 0, n_bad = 0;
  int D = 8, tcnt = 0, cyc = 0;
  int n_pulse = 0, rise_at = 0, last_rise = 0, width_bad = 0, last_w = 0;
  int exp_w = 0, spacing_bad = 0, echo_low = 0;
  int rx_fall_at = 0, rx_w = 0;
  logic prev_out = 1'b0, prev_rx = 1'b1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // tick generator and output monitor, both away from the active edge
  always @(negedge clk) begin
    baud_tick = (tcnt >= D - 1);
    tcnt = (tcnt >= D - 1) ? 0 : tcnt + 1;
  end

  always @(negedge clk) begin
    cyc++;
    if (sir_en && sir_out && !prev_out) begin
      if (n_pulse > 0 && ((cyc - last_rise) % (16 * D)) != 0) spacing_bad++;
      n_pulse++;
      rise_at = cyc;
      last_rise = cyc;
    end
    if (sir_en && !sir_out && prev_out) begin
      last_w = cyc - rise_at;
      if (last_w != exp_w) width_bad++;
    end
    if (sir_en && !uart_rxd) echo_low++;
    if (sir_en && !uart_rxd && prev_rx) rx_fall_at = cyc;
    if (sir_en && uart_rxd && !prev_rx) rx_w = cyc - rx_fall_at;
    prev_out = sir_out;
    prev_rx = uart_rxd;
  end

  function automatic int zeros_in(input logic [7:0] d, input int nb);
    int z = 0;
    for (int i = 0; i < nb; i++) if (!d[i]) z++;
    return z;
  endfunction

  function automatic int expect_pulses(input logic [7:0] d, input int nb, input bit lp, input int n);
    if (lp && n == 0) return 0;
    return 1 + zeros_in(d, nb);
  endfunction

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
  endtask

  task automatic send_bits(input logic [7:0] d, input int nb);
    wait_tick(); @(negedge clk); uart_txd = 1'b0;
    for (int i = 0; i < nb; i++) begin
      repeat (16) wait_tick(); @(negedge clk); uart_txd = d[i];
    end
    repeat (16) wait_tick(); @(negedge clk); uart_txd = 1'b1;
    repeat (16) wait_tick();
  endtask

  task automatic inject_echo(input int nb);
    repeat (2 * D + 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      repeat (5 + $urandom % 8) @(negedge clk);
      sir_in = 1'b1;
      repeat (3) @(negedge clk);
      sir_in = 1'b0;
    end
  endtask

  task automatic tx_frame(input logic [7:0] d, input int nb, input bit lp, input int n, input bit echo);
    int exp_n;
    @(negedge clk);
    lp_mode = lp; lp_div = 9'(n);
    exp_w = lp ? 3 * n : 3 * D;
    exp_n = expect_pulses(d, nb, lp, n);
    @(posedge clk);
    n_pulse = 0; width_bad = 0; spacing_bad = 0; echo_low = 0; last_w = exp_w;
    if (echo) fork send_bits(d, nb); inject_echo(nb); join
    else send_bits(d, nb);
    repeat (32) wait_tick();
    if (lp && n == 0) chk(n_pulse == 0, "R5", "pulses with zero divisor", n_pulse, 0);
    else chk(n_pulse == exp_n, "R2", "pulse count", n_pulse, exp_n);
    if (exp_n > 0) begin
      if (lp) chk(width_bad == 0, "R4", "low-power width", last_w, exp_w);
      else    chk(width_bad == 0, "R3", "normal width", last_w, exp_w);
      chk(spacing_bad == 0, "R2", "pulse spacing off bit grid", spacing_bad, 0);
    end
    if (echo) chk(echo_low == 0, "R7", "rxd low cycles while sending", echo_low, 0);
  endtask

  task automatic rx_frame(input logic [7:0] d, input int nb);
    logic [9:0] bits;
    bits = {1'b1, d, 1'b0};
    wait_tick();
    for (int k = 0; k <= nb + 1; k++) begin
      logic b;
      b = (k == nb + 1) ? 1'b1 : bits[k];
      @(negedge clk);
      if (!b) sir_in = 1'b1;
      repeat (3) @(negedge clk);
      sir_in = 1'b0;
      repeat (8 * D - 3) @(negedge clk);
      chk(uart_rxd == b, "R6", "mid-bit rxd", int'(uart_rxd), int'(b));
      repeat (8) wait_tick();
    end
    repeat (16) wait_tick();
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    chk(sir_out == 1'b0, "R8", "sir_out in reset", int'(sir_out), 0);
    chk(uart_rxd == 1'b1, "R8", "uart_rxd in reset", int'(uart_rxd), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: direct pass-through
    sir_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      uart_txd = 1'($urandom);
      sir_in = 1'($urandom);
      #1;
      chk(sir_out == uart_txd, "R1", "sir_out follows txd", int'(sir_out), int'(uart_txd));
      chk(uart_rxd == sir_in, "R1", "rxd follows sir_in", int'(uart_rxd), int'(sir_in));
    end
    @(negedge clk); uart_txd = 1'b1; sir_in = 1'b0; sir_en = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners
    tx_frame(8'hFF, 8, 1'b0, 0, 1'b0);   // R2 only the start bit pulses
    tx_frame(8'h00, 8, 1'b0, 0, 1'b0);   // R2 back-to-back zero bits
    tx_frame(8'h5A, 8, 1'b1, 0, 1'b0);   // R5
    tx_frame(8'h3C, 8, 1'b1, 1, 1'b0);   // R4 smallest divisor
    D = 64;
    tx_frame(8'hA5, 8, 1'b1, 256, 1'b0); // R4 largest divisor
    tx_frame(8'h96, 8, 1'b1, 5, 1'b0);   // R4 width independent of tick rate
    D = 8;

    // random frames, some with echo on the infrared input
    for (int i = 0; i < 20; i++) begin
      int nb, n;
      bit lp;
      nb = 5 + $urandom % 4;
      lp = 1'($urandom);
      n = 1 + $urandom % 30;
      tx_frame(8'($urandom), nb, lp, n, 1'($urandom));
    end
    tx_frame(8'h0F, 8, 1'b0, 0, 1'b1);   // R7 directed echo

    // receive path
    rx_frame(8'h35, 8);
    for (int i = 0; i < 4; i++) rx_frame(8'($urandom), 8);
    rx_frame(8'hFE, 8);                  // isolated zero pulses
    chk(rx_w >= 15 * D && rx_w <= 16 * D, "R6", "stretched low width", rx_w, 16 * D);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 190000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule